// File: doc/BRIEF.md
# Sequenced-Service Watchdog Timer

A watchdog timer for a 16-bit register bus. A prescaler divides the system clock into a slow tick. An 8-bit timeout field in the control register loads a down-counter, and the counter steps once per tick. If the counter reaches zero before software services it, the block drives a one-clock action pulse and records a timeout cause in a status register.

Software services the watchdog with two writes to the service register: first 16'h5555, then 16'hAAAA as the very next service write. Software can also ask for the action directly. It does this by writing the software-reset bit of the control register as 0, or by enabling the block with a timeout of zero. Once set, the enable bit stays set until block reset. The bus carries one 16-bit word per access, with a valid strobe, a write flag, a byte address and write data. Read data is returned in the same cycle.

Top module: `wdog_svc_top`

## Requirements
- R1: After reset the registers read as follows: control (offset 0x0) 16'h0030, service (0x2) 0, status (0x4) 0, misc (0x8) 16'h0001. action_o is low.
- R2: Control bit 2 is the enable. Once it is written as 1, later control writes cannot clear it until rst_ni is asserted.
- R3: A control write with bit 4 (software-reset request) at 0 pulses action_o in the next cycle. It sets status to 16'h0002 (bit 1 = software cause). Control bit 4 then reads back as 1.
- R4: A control write that leaves enable set with timeout field bits 15:8 at zero pulses action_o in the next cycle, and status does not change.
- R5: With enable set and timeout T nonzero, the counter loads T+1. It counts down once every PRESCALE clocks. action_o goes high exactly (T+1)*PRESCALE clocks after the loading write, and status becomes 16'h0010 (bit 4 = timeout cause).
- R6: A service write of 16'hAAAA restarts the countdown only when the previous service write was 16'h5555. Any other value in between breaks the sequence. Each service write is stored and reads back.
- R7: Every control write restarts the countdown from the newly written timeout.
- R8: action_o lasts one clock. After an expiry the counter stops, so no further pulse follows until a reload.
- R9: Writes to status, to offset 0x6, to unmapped offsets and to odd addresses have no effect. Only misc bit 0 is writable. Reads of offset 0x6, unmapped offsets and odd addresses return 0.
- R10: With enable clear, or with the timeout at zero, the counter does not run and no expiry pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address; bit 0 must be 0 |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, same cycle as the access |
| action_o | output | 1 | One-clock watchdog action pulse |

## Verification
The bench checks the expiry instant to the exact clock, so an off-by-one in the T+1 load or in the prescaler phase shows up as a pulse one tick early or late. It runs a broken service sequence (5555, other value, AAAA). A design that only compares the current write against 16'hAAAA would wrongly restart and miss the original expiry. It writes enable as 0 after setting it, with a zero timeout: a non-sticky enable would skip the immediate pulse and read back bit 2 clear. It also overwrites the status register, misc, odd addresses and offset 0x6, where a leaky decoder would change read-back values or the control register.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW = 16;
  localparam int TW = 8;

  localparam int CTL_EN   = 2;
  localparam int CTL_SWR  = 4;
  localparam int CTL_ASRT = 5;
  localparam int TOUT_LSB = 8;

  localparam int ST_SOFT  = 1;
  localparam int ST_TOUT  = 4;
  localparam int MISC_PDE = 0;

  localparam logic [DW-1:0] CTRL_RST  = 16'h0030;
  localparam logic [DW-1:0] MISC_RST  = 16'h0001;
  localparam logic [DW-1:0] SVC_KEY_A = 16'h5555;
  localparam logic [DW-1:0] SVC_KEY_B = 16'hAAAA;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_SVC  = 3'd1,
    SEL_STAT = 3'd2,
    SEL_ICTL = 3'd3,
    SEL_MISC = 3'd4,
    SEL_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRESCALE = 125_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          run_i,
  input  logic [TW-1:0] tout_i,
  input  logic          tick_i,
  output logic          expire_o,
  output logic          running_o
);
  logic [TW:0] count_q;
  logic        running_q;

  assign expire_o  = running_q && tick_i && !load_i && (count_q == (TW+1)'(1));
  assign running_o = running_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      running_q <= 1'b0;
    end else if (load_i) begin
      count_q   <= run_i ? ({1'b0, tout_i} + 1'b1) : '0;
      running_q <= run_i;
    end else if (running_q && tick_i) begin
      count_q <= count_q - 1'b1;
      if (count_q == (TW+1)'(1)) running_q <= 1'b0;
    end
  end

  p_stop_after_expiry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !running_q);
  p_count_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && !load_i) |=> (count_q <= $past(count_q)));
  p_run_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q |-> (count_q != '0));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic              expire_i,
  output logic              action_o,
  output logic              load_o,
  output logic              load_run_o,
  output logic [TW-1:0]     tout_o,
  output logic              en_o
);
  logic [DW-1:0] ctrl_q, svc_q, stat_q, misc_q, ctrl_nx;
  logic          action_q;
  reg_sel_e      sel;
  logic          ctl_we, svc_we, stat_we, misc_we, svc_hit, sw_act;

  always_comb begin
    sel = SEL_NONE;
    if (!bus_addr_i[0]) begin
      unique case (int'(bus_addr_i[ADDR_W-1:1]))
        0:       sel = SEL_CTRL;
        1:       sel = SEL_SVC;
        2:       sel = SEL_STAT;
        3:       sel = SEL_ICTL;
        4:       sel = SEL_MISC;
        default: sel = SEL_NONE;
      endcase
    end
  end

  assign ctl_we  = bus_valid_i && bus_write_i && (sel == SEL_CTRL);
  assign svc_we  = bus_valid_i && bus_write_i && (sel == SEL_SVC);
  assign stat_we = bus_valid_i && bus_write_i && (sel == SEL_STAT);
  assign misc_we = bus_valid_i && bus_write_i && (sel == SEL_MISC);

  // staged control value: enable is sticky, software-reset bit self-sets
  always_comb begin
    ctrl_nx          = bus_wdata_i;
    ctrl_nx[CTL_EN]  = bus_wdata_i[CTL_EN] | ctrl_q[CTL_EN];
    ctrl_nx[CTL_SWR] = 1'b1;
  end

  assign sw_act  = ctl_we && (!bus_wdata_i[CTL_SWR] ||
                   (ctrl_nx[CTL_EN] && (ctrl_nx[DW-1:TOUT_LSB] == '0)));
  assign svc_hit = svc_we && (svc_q == SVC_KEY_A) && (bus_wdata_i == SVC_KEY_B);

  assign load_o     = ctl_we || svc_hit;
  assign tout_o     = ctl_we ? ctrl_nx[DW-1:TOUT_LSB] : ctrl_q[DW-1:TOUT_LSB];
  assign en_o       = ctrl_q[CTL_EN];
  assign load_run_o = ctl_we ? (ctrl_nx[CTL_EN] && (ctrl_nx[DW-1:TOUT_LSB] != '0))
                             : (ctrl_q[CTL_EN]  && (ctrl_q[DW-1:TOUT_LSB]  != '0));
  assign action_o   = action_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_RST;
      svc_q    <= '0;
      stat_q   <= '0;
      misc_q   <= MISC_RST;
      action_q <= 1'b0;
    end else begin
      action_q <= sw_act || expire_i;
      if (ctl_we) ctrl_q <= ctrl_nx;
      if (svc_we) svc_q <= bus_wdata_i;
      if (misc_we) misc_q <= bus_wdata_i & MISC_RST;
      if (ctl_we && !bus_wdata_i[CTL_SWR]) begin
        stat_q          <= '0;
        stat_q[ST_SOFT] <= 1'b1;
      end else if (expire_i) begin
        stat_q          <= '0;
        stat_q[ST_TOUT] <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_valid_i && !bus_write_i) begin
      unique case (sel)
        SEL_CTRL: bus_rdata_o = ctrl_q;
        SEL_SVC:  bus_rdata_o = svc_q;
        SEL_STAT: bus_rdata_o = stat_q;
        SEL_MISC: bus_rdata_o = misc_q;
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  p_enable_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CTL_EN] |=> ctrl_q[CTL_EN]);
  p_swr_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we && !bus_wdata_i[CTL_SWR]) |=> (stat_q[ST_SOFT] && action_o && ctrl_q[CTL_SWR]));
  p_zero_tout_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we && bus_wdata_i[CTL_SWR] && ctrl_nx[CTL_EN] && (bus_wdata_i[DW-1:TOUT_LSB] == '0))
      |=> (action_o && $stable(stat_q)));
  p_expire_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> (stat_q[ST_TOUT] && action_o));
  p_svc_tracks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_we |=> (svc_q == $past(bus_wdata_i)));
  p_status_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we && !expire_i) |=> $stable(stat_q));
  p_misc_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misc_q[DW-1:1] == '0);
endmodule

// File: rtl/wdog_svc_top.sv
module wdog_svc_top
  import wdog_pkg::*;
#(
  parameter int PRESCALE = 125_000_000,
  parameter int ADDR_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              action_o
);
  logic          tick, expire, running, load, load_run, en;
  logic [TW-1:0] tout;

  wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .bus_valid_i, .bus_write_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o,
    .expire_i   (expire),
    .action_o,
    .load_o     (load),
    .load_run_o (load_run),
    .tout_o     (tout),
    .en_o       (en)
  );

  wdog_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i, .rst_ni,
    .restart_i (load),
    .tick_o    (tick)
  );

  wdog_countdown #(.TW(TW)) u_cnt (
    .clk_i, .rst_ni,
    .load_i    (load),
    .run_i     (load_run),
    .tout_i    (tout),
    .tick_i    (tick),
    .expire_o  (expire),
    .running_o (running)
  );

  p_run_needs_enable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> en);
  p_no_expire_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> !expire);
endmodule

// File: tb/wdog_svc_top_tb.sv
`timescale 1ns/1ps
module wdog_svc_top_tb;
  localparam int P = 8;

  typedef struct {
    logic [15:0] exp;
    logic [3:0]  addr;
    string       req;
  } rd_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        action;

  int n_chk = 0, n_fail = 0, pulses = 0;
  bit done = 0;
  rd_item_t sb_q[$];

  always #2 clk = ~clk;

  wdog_svc_top #(.PRESCALE(P), .ADDR_W(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .action_o(action)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops expected read items and compares mid-cycle
  always @(negedge clk) begin
    if (action === 1'b1) pulses++;
    if (valid && !wr && sb_q.size() > 0) begin
      rd_item_t it;
      it = sb_q.pop_front();
      chk(it.req, rdata, it.exp);
    end
  end

  task automatic bus_wr(logic [3:0] a, logic [15:0] d);
    @(posedge clk); #1 valid = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1 valid = 0; wr = 0;
  endtask

  task automatic bus_rd(logic [3:0] a, logic [15:0] e, string req);
    rd_item_t it;
    it.exp = e; it.addr = a; it.req = req;
    @(posedge clk); #1 valid = 1; wr = 0; addr = a; sb_q.push_back(it);
    @(posedge clk); #1 valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  // called just after edge X; expects a single pulse raised at edge X+k
  task automatic expect_pulse(int k, string req);
    int p0;
    p0 = pulses;
    repeat (k - 1) @(posedge clk);
    @(negedge clk); #1 chk(req, 16'(action), 16'h0);
    chk(req, 16'(pulses - p0), 16'h0);
    @(posedge clk); @(negedge clk); #1 chk(req, 16'(action), 16'h1);
    @(posedge clk); @(negedge clk); #1 chk({req, "/R8"}, 16'(action), 16'h0);
  endtask

  task automatic expect_sw_pulse(string req);
    @(negedge clk); #1 chk(req, 16'(action), 16'h1);
  endtask

  task automatic quiet(int n, string req);
    int p0;
    p0 = pulses;
    repeat (n) @(posedge clk);
    @(negedge clk); #1 chk(req, 16'(pulses - p0), 16'h0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    @(negedge clk); chk("R1", 16'(action), 16'h0);
    bus_rd(4'h0, 16'h0030, "R1");
    bus_rd(4'h2, 16'h0000, "R1");
    bus_rd(4'h4, 16'h0000, "R1");
    bus_rd(4'h8, 16'h0001, "R1");

    // R9 ignored / masked writes
    bus_wr(4'h4, 16'hFFFF); bus_rd(4'h4, 16'h0000, "R9");
    bus_wr(4'h8, 16'hFFFF); bus_rd(4'h8, 16'h0001, "R9");
    bus_wr(4'h8, 16'h0000); bus_rd(4'h8, 16'h0000, "R9");
    bus_wr(4'h6, 16'hFFFF); bus_rd(4'h6, 16'h0000, "R9");
    bus_rd(4'hA, 16'h0000, "R9");
    bus_wr(4'h1, 16'h0234); bus_rd(4'h0, 16'h0030, "R9");
    bus_rd(4'h1, 16'h0000, "R9");
    quiet(20, "R9");

    // R10 disabled with nonzero timeout never expires
    bus_wr(4'h0, 16'h0230);
    quiet(100, "R10");

    // R4 enable with zero timeout, status untouched
    bus_wr(4'h0, 16'h0034); expect_sw_pulse("R4");
    bus_rd(4'h4, 16'h0000, "R4");
    // R2 enable cannot be cleared
    bus_wr(4'h0, 16'h0030); expect_sw_pulse("R4");
    bus_rd(4'h0, 16'h0034, "R2");
    quiet(100, "R10");

    // R5 / R8 expiry timing and cause
    do_reset();
    bus_wr(4'h0, 16'h0334); expect_pulse(4 * P, "R5");
    bus_rd(4'h4, 16'h0010, "R5");
    quiet(100, "R8");

    // R7 control write reloads from new timeout
    bus_wr(4'h0, 16'h0534);
    repeat (10) @(posedge clk);
    bus_wr(4'h0, 16'h0134); expect_pulse(2 * P, "R7");
    quiet(60, "R7");

    // R6 good service sequence
    bus_wr(4'h0, 16'h0334);
    repeat (20) @(posedge clk);
    bus_wr(4'h2, 16'h5555);
    bus_wr(4'h2, 16'hAAAA); expect_pulse(4 * P, "R6");
    bus_rd(4'h2, 16'hAAAA, "R6");

    // R6 broken sequence: no restart
    bus_wr(4'h0, 16'h0334);
    bus_wr(4'h2, 16'h5555);
    bus_wr(4'h2, 16'h1234);
    bus_wr(4'h2, 16'hAAAA); expect_pulse(4 * P - 6, "R6");

    // R3 software request replaces cause, bit reads back 1, countdown restarts
    bus_wr(4'h0, 16'h0324); expect_sw_pulse("R3");
    bus_rd(4'h4, 16'h0002, "R3");
    bus_rd(4'h0, 16'h0334, "R3");
    expect_pulse(4 * P - 4, "R5");
    bus_rd(4'h4, 16'h0010, "R5");

    repeat (2) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule